// File: doc/BRIEF.md
# ADC Conversion Control and Status Register

This block is the digital control side of a single-result analog-to-digital converter. A CPU reaches it over a simple register bus that has read, write, byte-enable and read-modify-write qualifiers. One 16-bit control/status word holds the run state, the completion flag, the interrupt enable, the DMA pause flag, the trigger source select and the conversion mode. A second address returns the last conversion result. The block drives a one-cycle start request to the analog converter. It captures the result when the converter's done strobe arrives, and it raises an interrupt request and a DMA service request.

Starts can come from a software write, an external trigger pin or a timer pulse, and the source-select field decides which hardware triggers count. There are three conversion modes. Single mode converts once and goes idle. Continuous mode restarts by itself after each result. Stop mode accepts hardware triggers only. There is only one result register, so continuous mode with DMA enabled pauses after every result. It resumes by itself once the DMA engine acknowledges that the result has been moved.

Top module: `adc_ctl_csr`

## Requirements
- R1: After reset every control/status field and the result register are 0, and conv_start, busy, irq and dma_req are low. A plain read of the control word returns 16'h0200.
- R2: A write with bus_be[1]=1, bit 15=1 and bit 9=1, made while neither running (bit 15) nor paused (bit 12) and not in stop mode, pulses conv_start for one cycle in the cycle after the write. busy rises in that same cycle. A start write made while running is ignored.
- R3: Writing 0 to bit 15 (bus_be[1]=1) clears the running and paused state at once and cancels any start in that cycle, including a bit 9 start in the same write. Writing 1 to bit 15 changes nothing.
- R4: conv_done while running loads conv_data into the result register and sets bit 14. conv_done while not running is ignored.
- R5: Bit 14 clears when 0 is written to it (bus_be[1]=1) or when dma_ack arrives while bit 2 is 1. Writing 1 leaves it unchanged. A completion in the same cycle wins over either clear.
- R6: irq is high exactly when bit 14 and bit 13 are both 1.
- R7: Bits 11:10 select the hardware triggers that may start an idle converter. Bit 10 enables ext_trig and bit 11 enables tmr_trig, so 00 means software only and 11 accepts both. A newly written field takes effect from the next cycle.
- R8: Triggers and start writes that arrive while running or paused are dropped, not queued.
- R9: Bits 1:0 select the mode: 00 or 11 is single, 01 is continuous, 10 is stop. In single and stop mode, completion clears busy. In continuous mode with bit 2=0, completion issues a new conv_start in the next cycle and busy stays high.
- R10: In continuous mode with bit 2=1, completion sets bit 12 and clears busy, so later done strobes and triggers are ignored. dma_ack then clears bits 12 and 14, sets busy and pulses conv_start in the next cycle.
- R11: In stop mode a bit 9 start write is ignored, while enabled hardware triggers still start a conversion.
- R12: Bit 9 reads 1 on a plain read and 0 when bus_rmw is 1. Bit 8 and bits 7:3 always read 0, and writes to them are ignored. bus_rdata is 0 when bus_rd is low.
- R13: bus_be[1] gates every effect of bits 15:8 and bus_be[0] gates every effect of bits 7:0.
- R14: A read with bus_addr=1 returns the result zero-extended to 16 bits. dma_req is high exactly when bit 14 and bit 2 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_rmw | input | 1 | Marks the read as part of a read-modify-write |
| bus_addr | input | 1 | 0 selects the control word, 1 selects the result |
| bus_be | input | 2 | Byte enables, bit 1 for the upper byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | RES_W | Converter result |
| ext_trig | input | 1 | External trigger pulse |
| tmr_trig | input | 1 | Timer trigger pulse |
| dma_ack | input | 1 | DMA transfer-complete acknowledge |
| conv_start | output | 1 | One-cycle start request to the converter |
| busy | output | 1 | Conversion in progress |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA service request |

## Verification
The bench builds the block with its default RES_W of 10. At that width the converter result fills only the low part of the read word, so the zero-extension of the result read can be seen on the bus. Only two hardware trigger lines exist, so every value of the source-select field is reachable, including the case where both triggers are enabled. With a short result and no timing parameters, the pause-and-resume loop, forced stops in the middle of a conversion and same-cycle collisions between done strobes, acknowledges and writes all happen within a few cycles each. That leaves room for a long randomized stretch compared against the reference model on every clock.

// File: rtl/adc_csr_pkg.sv
package adc_csr_pkg;

    localparam int unsigned WORD_W  = 16;
    localparam int unsigned NUM_HW  = 2;

    // control word bit positions (order is observable on the bus)
    localparam int unsigned B_RUN   = 15;
    localparam int unsigned B_DONE  = 14;
    localparam int unsigned B_IEN   = 13;
    localparam int unsigned B_HOLD  = 12;
    localparam int unsigned B_SRCHI = 11;
    localparam int unsigned B_SRCLO = 10;
    localparam int unsigned B_GO    = 9;
    localparam int unsigned B_DMAEN = 2;

    typedef enum logic [1:0] {
        MODE_ONCE  = 2'b00,
        MODE_LOOP  = 2'b01,
        MODE_HWONLY = 2'b10,
        MODE_ONCE2 = 2'b11
    } conv_mode_e;

    typedef struct packed {
        logic              run;
        logic              done_f;
        logic              ien;
        logic              hold;
        logic [NUM_HW-1:0] src;
        logic              dmaen;
        conv_mode_e        mode;
        logic              go_pulse;
    } csr_state_t;

endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
    parameter int unsigned NUM_HW = 2
) (
    input  logic [NUM_HW-1:0] src_en,
    input  logic [NUM_HW-1:0] hw_trig,
    output logic              hit
);
    logic [NUM_HW-1:0] gated;

    for (genvar i = 0; i < NUM_HW; i++) begin : g_gate
        assign gated[i] = src_en[i] & hw_trig[i];
    end

    assign hit = |gated;
endmodule

// File: rtl/adc_csr_rdmux.sv
module adc_csr_rdmux
    import adc_csr_pkg::*;
#(
    parameter int unsigned RES_W = 10
) (
    input  logic              rd,
    input  logic              rmw,
    input  logic              sel_res,
    input  csr_state_t        st,
    input  logic [RES_W-1:0]  res,
    output logic [WORD_W-1:0] rdata
);
    localparam int unsigned PAD_W = WORD_W - RES_W;

    logic [WORD_W-1:0] ctl_word;
    logic [WORD_W-1:0] res_word;

    always_comb begin
        ctl_word          = '0;
        ctl_word[B_RUN]   = st.run;
        ctl_word[B_DONE]  = st.done_f;
        ctl_word[B_IEN]   = st.ien;
        ctl_word[B_HOLD]  = st.hold;
        ctl_word[B_SRCHI:B_SRCLO] = st.src;
        ctl_word[B_GO]    = ~rmw;
        ctl_word[B_DMAEN] = st.dmaen;
        ctl_word[1:0]     = st.mode;
    end

    assign res_word = {{PAD_W{1'b0}}, res};
    assign rdata    = !rd ? '0 : (sel_res ? res_word : ctl_word);
endmodule

// File: rtl/adc_ctl_csr.sv
module adc_ctl_csr
    import adc_csr_pkg::*;
#(
    parameter int unsigned RES_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_rmw,
    input  logic              bus_addr,
    input  logic [1:0]        bus_be,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data,
    input  logic              ext_trig,
    input  logic              tmr_trig,
    input  logic              dma_ack,
    output logic              conv_start,
    output logic              busy,
    output logic              irq,
    output logic              dma_req
);
    csr_state_t        st_d, st_q;
    logic [RES_W-1:0]  res_d, res_q;

    logic hw_hit;
    logic wr_ctl, wr_hi, wr_lo;
    logic stop_cmd, sw_go, accept_done, idle;
    logic unused_wbits;

    assign unused_wbits = ^{bus_wdata[8:3]};

    adc_trig_sel #(.NUM_HW(NUM_HW)) u_trig (
        .src_en  (st_q.src),
        .hw_trig ({tmr_trig, ext_trig}),
        .hit     (hw_hit)
    );

    adc_csr_rdmux #(.RES_W(RES_W)) u_rd (
        .rd      (bus_rd),
        .rmw     (bus_rmw),
        .sel_res (bus_addr),
        .st      (st_q),
        .res     (res_q),
        .rdata   (bus_rdata)
    );

    always_comb begin
        st_d          = st_q;
        res_d         = res_q;
        st_d.go_pulse = 1'b0;

        wr_ctl      = bus_wr & ~bus_addr;
        wr_hi       = wr_ctl & bus_be[1];
        wr_lo       = wr_ctl & bus_be[0];
        stop_cmd    = wr_hi & ~bus_wdata[B_RUN];
        sw_go       = wr_hi & bus_wdata[B_GO] & (st_q.mode != MODE_HWONLY);
        accept_done = conv_done & st_q.run;
        idle        = ~st_q.run & ~st_q.hold;

        if (wr_lo) begin
            st_d.mode  = conv_mode_e'(bus_wdata[1:0]);
            st_d.dmaen = bus_wdata[B_DMAEN];
        end
        if (wr_hi) begin
            st_d.ien = bus_wdata[B_IEN];
            st_d.src = bus_wdata[B_SRCHI:B_SRCLO];
        end

        if (accept_done) begin
            res_d       = conv_data;
            st_d.done_f = 1'b1;
            if (st_q.mode == MODE_LOOP) begin
                if (st_q.dmaen) begin
                    st_d.run  = 1'b0;
                    st_d.hold = 1'b1;
                end else begin
                    st_d.go_pulse = 1'b1;
                end
            end else begin
                st_d.run = 1'b0;
            end
        end else if ((wr_hi && !bus_wdata[B_DONE]) || (dma_ack && st_q.dmaen)) begin
            st_d.done_f = 1'b0;
        end

        if (st_q.hold && dma_ack && st_q.dmaen) begin
            st_d.hold     = 1'b0;
            st_d.run      = 1'b1;
            st_d.go_pulse = 1'b1;
        end

        if (idle && (hw_hit || sw_go)) begin
            st_d.run      = 1'b1;
            st_d.go_pulse = 1'b1;
        end

        if (stop_cmd) begin
            st_d.run      = 1'b0;
            st_d.hold     = 1'b0;
            st_d.go_pulse = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '0;
            res_q <= '0;
        end else begin
            st_q  <= st_d;
            res_q <= res_d;
        end
    end

    assign conv_start = st_q.go_pulse;
    assign busy       = st_q.run;
    assign irq        = st_q.done_f & st_q.ien;
    assign dma_req    = st_q.done_f & st_q.dmaen;
endmodule

// File: rtl/adc_ctl_csr_chk.sv
module adc_ctl_csr_chk #(
    parameter int unsigned RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_start,
    input logic             busy,
    input logic             irq,
    input logic             ien,
    input logic             done_f,
    input logic             hold,
    input logic             conv_done,
    input logic [RES_W-1:0] result
);
    AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy); // R2

    AST_HOLD_NOT_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !busy); // R10

    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && busy) |=> done_f); // R4

    AST_RESULT_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(result)); // R4

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ien); // R6
endmodule

bind adc_ctl_csr adc_ctl_csr_chk #(.RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .busy       (busy),
    .irq        (irq),
    .ien        (st_q.ien),
    .done_f     (st_q.done_f),
    .hold       (st_q.hold),
    .conv_done  (conv_done),
    .result     (res_q)
);

// File: tb/adc_ctl_csr_bench.sv
`timescale 1ns/1ps
module adc_ctl_csr_bench;
    localparam int RES_W = 10;

    logic clk = 0;
    logic rst_n = 0;
    logic bus_wr = 0, bus_rd = 0, bus_rmw = 0, bus_addr = 0;
    logic [1:0] bus_be = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic conv_done = 0;
    logic [RES_W-1:0] conv_data = 0;
    logic ext_trig = 0, tmr_trig = 0, dma_ack = 0;
    logic conv_start, busy, irq, dma_req;

    int vecs = 0;
    int errs = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    adc_ctl_csr #(.RES_W(RES_W)) u_adc_ctl_csr (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rmw(bus_rmw), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_done(conv_done),
        .conv_data(conv_data), .ext_trig(ext_trig), .tmr_trig(tmr_trig),
        .dma_ack(dma_ack), .conv_start(conv_start), .busy(busy), .irq(irq),
        .dma_req(dma_req)
    );

    // reference model state
    bit m_run, m_flag, m_ien, m_hold, m_dmaen, m_go;
    bit [1:0] m_src, m_mode;
    int m_res;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_flag = 0; m_ien = 0; m_hold = 0; m_dmaen = 0;
            m_go = 0; m_src = 0; m_mode = 0; m_res = 0;
        end else begin
            bit was_run, was_hold, was_dma, hi, lo, got, go;
            bit [1:0] was_src, was_mode;
            was_run = m_run; was_hold = m_hold; was_dma = m_dmaen;
            was_src = m_src; was_mode = m_mode;
            hi = bus_wr && !bus_addr && bus_be[1];
            lo = bus_wr && !bus_addr && bus_be[0];
            got = conv_done && was_run;
            go = 0;
            if (lo) begin m_mode = bus_wdata[1:0]; m_dmaen = bus_wdata[2]; end
            if (hi) begin m_ien = bus_wdata[13]; m_src = bus_wdata[11:10]; end
            if (got) begin
                m_res = int'(conv_data);
                m_flag = 1;
                if (was_mode == 2'b01 && was_dma) begin m_run = 0; m_hold = 1; end
                else if (was_mode == 2'b01) go = 1;
                else m_run = 0;
            end else begin
                if (hi && !bus_wdata[14]) m_flag = 0;
                if (dma_ack && was_dma) m_flag = 0;
            end
            if (was_hold && was_dma && dma_ack) begin m_hold = 0; m_run = 1; go = 1; end
            if (!was_run && !was_hold &&
                ((ext_trig && was_src[0]) || (tmr_trig && was_src[1]) ||
                 (hi && bus_wdata[9] && was_mode != 2'b10))) begin
                m_run = 1; go = 1;
            end
            if (hi && !bus_wdata[15]) begin m_run = 0; m_hold = 0; go = 0; end
            m_go = go;
        end
    end

    function automatic int exp_rdata();
        if (!bus_rd) return 0;
        if (bus_addr) return m_res;
        return (int'(m_run) << 15) | (int'(m_flag) << 14) | (int'(m_ien) << 13) |
               (int'(m_hold) << 12) | (int'(m_src) << 10) | (int'(!bus_rmw) << 9) |
               (int'(m_dmaen) << 2) | int'(m_mode);
    endfunction

    task automatic chk(string tag, int act, int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // compare outputs on every falling edge, before the next inputs are applied
    always @(negedge clk) if (rst_n && !finished) begin
        chk("R2 conv_start", int'(conv_start), int'(m_go));
        chk("R3 busy", int'(busy), int'(m_run));
        chk("R6 irq", int'(irq), int'(m_flag && m_ien));
        chk("R14 dma_req", int'(dma_req), int'(m_flag && m_dmaen));
        chk("R12 rdata", int'(bus_rdata), exp_rdata());
    end

    task automatic idle_bus();
        bus_wr = 0; bus_rd = 0; bus_rmw = 0; bus_addr = 0; bus_be = 0;
        conv_done = 0; ext_trig = 0; tmr_trig = 0; dma_ack = 0;
    endtask

    task automatic cyc(); @(negedge clk); #1 idle_bus(); endtask

    task automatic wr(logic [1:0] be, logic [15:0] d);
        @(negedge clk); #1 idle_bus();
        bus_wr = 1; bus_be = be; bus_wdata = d;
    endtask

    task automatic rd(logic a, logic rmw);
        @(negedge clk); #1 idle_bus();
        bus_rd = 1; bus_addr = a; bus_rmw = rmw;
    endtask

    task automatic done(logic [RES_W-1:0] v);
        @(negedge clk); #1 idle_bus();
        conv_done = 1; conv_data = v;
    endtask

    task automatic pulse(bit e, bit t, bit a);
        @(negedge clk); #1 idle_bus();
        ext_trig = e; tmr_trig = t; dma_ack = a;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state, plain read then RMW read
        rd(0, 0); @(negedge clk);
        chk("R1 reset word", int'(bus_rdata), 16'h0200);
        rd(0, 1); rd(1, 0);
        // R2 software start, single mode; R4 completion; R6 interrupt
        wr(2'b11, 16'hE200); cyc(); cyc();
        wr(2'b10, 16'hE200);           // R8 start while running ignored
        done(10'h2A5); rd(1, 0);       // R14 result zero-extended
        done(10'h111); rd(1, 0);       // R4 done while idle ignored
        // R5 flag clear by writing 0, writing 1 keeps
        wr(2'b10, 16'hE000); cyc();
        wr(2'b10, 16'hA000); rd(0, 0);
        // R7 source select: ext only
        wr(2'b10, 16'hA400); cyc();
        pulse(0, 1, 0); cyc();         // timer not enabled
        pulse(1, 0, 0); cyc();
        pulse(1, 1, 0); cyc();         // R8 dropped while running
        done(10'h0F0); cyc();
        wr(2'b10, 16'hAC00); pulse(0, 1, 0); cyc();  // R7 both enabled
        // R3 forced stop mid-conversion, then done ignored
        wr(2'b10, 16'h2C00); done(10'h3FF); rd(1, 0);
        wr(2'b10, 16'h2200); cyc();    // R3 stop plus start: no start
        // R13 lower byte only: upper start bits not applied
        wr(2'b01, 16'hE200); rd(0, 0);
        // R12 bit 8 and bits 7:3 ignored
        wr(2'b01, 16'h01F8); rd(0, 0); rd(0, 1);
        // R11 stop mode: software start ignored, trigger starts
        wr(2'b01, 16'h0002); wr(2'b10, 16'hA600); cyc();
        pulse(1, 0, 0); cyc(); done(10'h055); cyc();
        // R9 continuous without DMA
        wr(2'b01, 16'h0001); wr(2'b10, 16'hA200); cyc();
        done(10'h001); cyc(); done(10'h002); cyc();
        wr(2'b10, 16'h2000); cyc();
        // R10 continuous with DMA: pause, ignore, resume
        wr(2'b01, 16'h0005); wr(2'b10, 16'hA600); cyc();
        done(10'h123); rd(0, 0);
        pulse(1, 1, 0); done(10'h321); rd(1, 0);
        pulse(0, 0, 1); cyc(); rd(0, 0);
        done(10'h0AA); pulse(0, 0, 1); cyc();
        wr(2'b10, 16'h2000); cyc();
        // mixed stimulus against the model
        for (int i = 0; i < 3000; i++) begin
            int r;
            @(negedge clk); #1 idle_bus();
            r = $urandom;
            conv_done = r[0] & r[1];
            conv_data = RES_W'($urandom);
            ext_trig = r[2] & r[3];
            tmr_trig = r[4] & r[5];
            dma_ack = r[6] & r[7];
            bus_rd = r[8];
            bus_rmw = r[9];
            bus_addr = r[10];
            if (r[11] && r[12] && r[13]) begin
                bus_wr = 1; bus_be = r[15:14]; bus_wdata = 16'($urandom);
                if (r[16]) bus_wdata[15] = 1;
            end
        end
        cyc(); cyc();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule